// File: doc/BRIEF.md
# Dual-Channel Test Tone Generator

This block produces test audio for two independent channels, A and B, with one new 32-bit sample per channel each time the sample strobe is high. Each channel picks its own source: a programmed constant word, a pseudo-random word, or a sine tone with a programmable frequency step and a linear amplitude multiplier. The pseudo-random source is one 16-bit LFSR that both channels share. The LFSR state and its feedback bit are visible at the ports so that an external model can follow the sequence.

Channel B passes through a delay of a whole number of samples, from 0 to 15. A summing option replaces channel A with the saturated sum of channel A and the delayed channel B. Configuration inputs take effect at the next strobe. The block is meant to sit ahead of a sample sink that reads both outputs in the cycle after each strobe.

Top module: `tone_gen_dual`

## Requirements
- R1: After synchronous reset, both sample outputs are zero, the LFSR state is 0x0001, both sine phases are 0 and the delay history holds zeros.
- R2: The outputs, the LFSR and the sine phases change only in the clock cycle after a cycle with `smp_en` high. Without a strobe they hold their values.
- R3: On each strobe, whatever the source selects, the LFSR shifts left by one bit. The new bit 0 is the XOR of state bits 15, 13, 12 and 10, which is the polynomial x^16+x^14+x^13+x^11+1. The state is never zero.
- R4: Source code 1 (pseudo-random) gives a sample whose bits 31:16 and bits 15:0 both hold (L + 0x4000) mod 2^16. L is the LFSR state before that strobe's shift.
- R5: Source code 0 outputs the channel's programmed 32-bit constant. Source code 3 outputs zero.
- R6: Source code 2 (sine) gives sample k after reset as round(32767*sin(2*pi*p/3072)) multiplied by the unsigned 16-bit amplitude, with a sign-magnitude result in two's complement. The phase p equals k*N mod 3072, where N is the channel's step.
- R7: Each channel's phase advances by its own step N (0 to 1535) on every strobe, whatever the source selects, and wraps modulo 3072.
- R8: With lag d (0 to 15), channel B's output at strobe k is channel B's source sample of strobe k-d. For k < d after reset, the output is zero.
- R9: With `sum_en` high, channel A's output is the sum of channel A's source sample and channel B's delayed output, both signed, clamped to the range -2^31 to 2^31-1.
- R10: Each channel's source, constant, step and amplitude affect only that channel, except for the shared LFSR and the summing option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample strobe, one sample per high cycle |
| a_src | input | 2 | Channel A source: 0 constant, 1 pseudo-random, 2 sine, 3 zero |
| b_src | input | 2 | Channel B source, same encoding |
| a_dc | input | 32 | Channel A constant word |
| b_dc | input | 32 | Channel B constant word |
| a_step | input | 11 | Channel A phase step N |
| b_step | input | 11 | Channel B phase step N |
| a_amp | input | 16 | Channel A linear amplitude multiplier |
| b_amp | input | 16 | Channel B linear amplitude multiplier |
| b_lag | input | 4 | Delay of channel B, in samples |
| sum_en | input | 1 | Replace channel A with the saturated A+B sum |
| a_out | output | 32 | Channel A sample |
| b_out | output | 32 | Channel B sample |
| lfsr_state | output | 16 | Current LFSR state |
| lfsr_fb | output | 1 | Feedback bit that the next shift inserts |

## Verification
Constant words with opposite bit patterns on the two channels show whether a channel selects its own source and holds between strobes. Long pseudo-random runs compare every LFSR step and both halves of the word, which exposes a wrong tap or a wrong offset. Sine runs use a small step with unit amplitude and a near-Nyquist step with full amplitude, which exercises all four quadrants, the phase wrap and the widest product. Lags of 5 and 15 on a changing pseudo-random stream, a reset followed by a constant stream, and sums at both saturation limits and in the middle separate delay errors from summing errors.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    localparam int SMP_W     = 32;
    localparam int HALF_W    = 16;
    localparam int TAB_W     = 16;
    localparam int TAB_PEAK  = 32767;

    typedef enum logic [1:0] {
        SRC_DC   = 2'd0,
        SRC_PRBS = 2'd1,
        SRC_SINE = 2'd2,
        SRC_MUTE = 2'd3
    } src_e;

    typedef struct packed {
        src_e        src;
        logic [31:0] dc;
        logic [10:0] step;
        logic [15:0] amp;
    } chan_cfg_t;

    // Quarter-wave magnitude for index idx of qtr steps, computed by series.
    function automatic logic [TAB_W-1:0] qsin_val(input int idx, input int qtr);
        real x, term, s;
        x    = 1.5707963267948966 * real'(idx) / real'(qtr);
        term = x;
        s    = x;
        for (int k = 1; k <= 10; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            s    = s + term;
        end
        return TAB_W'($rtoi(s * real'(TAB_PEAK) + 0.5));
    endfunction

    function automatic logic [SMP_W-1:0] prbs_word(input logic [HALF_W-1:0] st);
        logic [HALF_W-1:0] h;
        h = st + HALF_W'(16'h4000);
        return {h, h};
    endfunction

    function automatic logic [SMP_W-1:0] sat_add(input logic [SMP_W-1:0] x,
                                                  input logic [SMP_W-1:0] y);
        logic [SMP_W:0] s;
        s = {x[SMP_W-1], x} + {y[SMP_W-1], y};
        if (s[SMP_W] != s[SMP_W-1])
            return s[SMP_W] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
        return s[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/tgen_lfsr.sv
module tgen_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'h0001,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] state,
    output logic         fb
);
    assign fb = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (rst)      state <= SEED;
        else if (adv) state <= {state[W-2:0], fb};
    end
endmodule

// File: rtl/tgen_sine.sv
module tgen_sine #(
    parameter int PH_MOD = 3072,
    parameter int STEP_W = 11,
    parameter int AMP_W  = 16,
    parameter int TAB_W  = 16,
    parameter int OUT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [STEP_W-1:0] step,
    input  logic [AMP_W-1:0]  amp,
    output logic [OUT_W-1:0]  sample
);
    localparam int QTR  = PH_MOD / 4;
    localparam int PH_W = $clog2(PH_MOD);

    logic [TAB_W-1:0] tab [QTR+1];
    for (genvar g = 0; g <= QTR; g++) begin : g_tab
        localparam logic [TAB_W-1:0] V = tgen_pkg::qsin_val(g, QTR);
        assign tab[g] = V;
    end

    logic [PH_W-1:0] acc;
    logic [PH_W:0]   nxt;
    logic [PH_W-1:0] idx;
    logic            neg;
    logic [OUT_W-1:0] prod;

    always_comb begin
        nxt = {1'b0, acc} + (PH_W+1)'(step);
        if (nxt >= (PH_W+1)'(PH_MOD)) nxt = nxt - (PH_W+1)'(PH_MOD);
    end

    always_comb begin
        neg = 1'b0;
        if (acc < PH_W'(QTR)) begin
            idx = acc;
        end else if (acc < PH_W'(2 * QTR)) begin
            idx = PH_W'(2 * QTR) - acc;
        end else if (acc < PH_W'(3 * QTR)) begin
            idx = acc - PH_W'(2 * QTR);
            neg = 1'b1;
        end else begin
            idx = PH_W'(4 * QTR) - acc;
            neg = 1'b1;
        end
    end

    assign prod   = OUT_W'(tab[idx]) * OUT_W'(amp);
    assign sample = neg ? (~prod + OUT_W'(1)) : prod;

    always_ff @(posedge clk) begin
        if (rst)      acc <= '0;
        else if (adv) acc <= nxt[PH_W-1:0];
    end
endmodule

// File: rtl/tgen_delay.sv
module tgen_delay #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int LAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [W-1:0]     din,
    input  logic [LAG_W-1:0] lag,
    output logic [W-1:0]     dout
);
    logic [W-1:0] hist [DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst)      hist[0] <= '0;
        else if (adv) hist[0] <= din;
    end

    for (genvar i = 1; i < DEPTH - 1; i++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst)      hist[i] <= '0;
            else if (adv) hist[i] <= hist[i-1];
        end
    end

    assign dout = (lag == '0) ? din : hist[lag - LAG_W'(1)];
endmodule

// File: rtl/tone_gen_dual.sv
module tone_gen_dual
    import tgen_pkg::*;
#(
    parameter int LAG_DEPTH = 16,
    parameter int PH_MOD    = 3072,
    parameter int LAG_W     = $clog2(LAG_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_en,
    input  logic [1:0]       a_src,
    input  logic [1:0]       b_src,
    input  logic [31:0]      a_dc,
    input  logic [31:0]      b_dc,
    input  logic [10:0]      a_step,
    input  logic [10:0]      b_step,
    input  logic [15:0]      a_amp,
    input  logic [15:0]      b_amp,
    input  logic [LAG_W-1:0] b_lag,
    input  logic             sum_en,
    output logic [31:0]      a_out,
    output logic [31:0]      b_out,
    output logic [15:0]      lfsr_state,
    output logic             lfsr_fb
);
    chan_cfg_t        cfg [2];
    logic [SMP_W-1:0] raw [2];
    logic [SMP_W-1:0] sine [2];
    logic [SMP_W-1:0] b_del;

    assign cfg[0] = '{src: src_e'(a_src), dc: a_dc, step: a_step, amp: a_amp};
    assign cfg[1] = '{src: src_e'(b_src), dc: b_dc, step: b_step, amp: b_amp};

    tgen_lfsr #(.W(HALF_W)) u_lfsr (
        .clk(clk), .rst(rst), .adv(smp_en), .state(lfsr_state), .fb(lfsr_fb)
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        tgen_sine #(.PH_MOD(PH_MOD), .TAB_W(TAB_W), .OUT_W(SMP_W)) u_sine (
            .clk(clk), .rst(rst), .adv(smp_en),
            .step(cfg[c].step), .amp(cfg[c].amp), .sample(sine[c])
        );

        always_comb begin
            unique case (cfg[c].src)
                SRC_DC:   raw[c] = cfg[c].dc;
                SRC_PRBS: raw[c] = prbs_word(lfsr_state);
                SRC_SINE: raw[c] = sine[c];
                default:  raw[c] = '0;
            endcase
        end
    end

    tgen_delay #(.W(SMP_W), .DEPTH(LAG_DEPTH), .LAG_W(LAG_W)) u_delay (
        .clk(clk), .rst(rst), .adv(smp_en), .din(raw[1]), .lag(b_lag), .dout(b_del)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_out <= '0;
            b_out <= '0;
        end else if (smp_en) begin
            a_out <= sum_en ? sat_add(raw[0], b_del) : raw[0];
            b_out <= b_del;
        end
    end
endmodule

// File: rtl/tone_gen_dual_chk.sv
module tone_gen_dual_chk (
    input logic        clk,
    input logic        rst,
    input logic        smp_en,
    input logic [1:0]  a_src,
    input logic [1:0]  b_src,
    input logic [31:0] a_dc,
    input logic [31:0] b_dc,
    input logic [3:0]  b_lag,
    input logic        sum_en,
    input logic [31:0] a_out,
    input logic [31:0] b_out,
    input logic [15:0] lfsr_state,
    input logic        lfsr_fb
);
    // R3
    lfsr_step_chk: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> lfsr_state == {$past(lfsr_state[14:0]), $past(lfsr_fb)});

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 16'h0000);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(a_out) && $stable(b_out) && $stable(lfsr_state));

    // R5
    dc_a_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_en && a_src == 2'd0 && !sum_en) |=> a_out == $past(a_dc));

    // R5
    mute_b_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_en && b_src == 2'd3 && b_lag == 4'd0) |=> b_out == 32'h0);

    // R4
    prbs_halves_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_en && a_src == 2'd1 && !sum_en) |=> a_out[31:16] == a_out[15:0]);

    // R8
    nolag_b_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_en && b_src == 2'd0 && b_lag == 4'd0) |=> b_out == $past(b_dc));
endmodule

bind tone_gen_dual tone_gen_dual_chk u_chk (
    .clk(clk), .rst(rst), .smp_en(smp_en), .a_src(a_src), .b_src(b_src),
    .a_dc(a_dc), .b_dc(b_dc), .b_lag(b_lag), .sum_en(sum_en),
    .a_out(a_out), .b_out(b_out), .lfsr_state(lfsr_state), .lfsr_fb(lfsr_fb)
);

// File: tb/tone_gen_dual_tb.sv
module tone_gen_dual_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_en = 1'b0;
    logic [1:0]  a_src = 2'd0, b_src = 2'd0;
    logic [31:0] a_dc = '0, b_dc = '0;
    logic [10:0] a_step = '0, b_step = '0;
    logic [15:0] a_amp = '0, b_amp = '0;
    logic [3:0]  b_lag = '0;
    logic        sum_en = 1'b0;
    logic [31:0] a_out, b_out;
    logic [15:0] lfsr_state;
    logic        lfsr_fb;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tone_gen_dual u_dut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .a_src(a_src), .b_src(b_src),
        .a_dc(a_dc), .b_dc(b_dc), .a_step(a_step), .b_step(b_step),
        .a_amp(a_amp), .b_amp(b_amp), .b_lag(b_lag), .sum_en(sum_en),
        .a_out(a_out), .b_out(b_out), .lfsr_state(lfsr_state), .lfsr_fb(lfsr_fb)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] l;
        string       tag;
    } item_t;

    item_t       sb [$];
    logic [15:0] m_lfsr;
    int          m_pha, m_phb;
    logic [31:0] m_hist [15];
    logic [31:0] last_a, last_b;
    logic        took = 1'b0;

    function automatic logic [31:0] sine_ref(int ph, logic [15:0] amp);
        real   ang;
        int    mag;
        logic [31:0] p;
        int    h;
        h   = (ph < 1536) ? ph : ph - 1536;
        ang = 2.0 * 3.14159265358979323846 * real'(h) / 3072.0;
        mag = $rtoi(32767.0 * $sin(ang) + 0.5);
        p   = 32'(mag) * 32'(amp);
        return (ph < 1536) ? p : -p;
    endfunction

    function automatic logic [31:0] src_ref(logic [1:0] s, logic [31:0] dc, int ph,
                                            logic [15:0] amp);
        logic [15:0] h;
        h = m_lfsr + 16'h4000;
        case (s)
            2'd0:    return dc;
            2'd1:    return {h, h};
            2'd2:    return sine_ref(ph, amp);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] sat_ref(logic [31:0] x, logic [31:0] y);
        longint s;
        s = longint'($signed(x)) + longint'($signed(y));
        if (s > 64'sd2147483647)  return 32'h7FFF_FFFF;
        if (s < -64'sd2147483648) return 32'h8000_0000;
        return s[31:0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_lfsr = 16'h0001;
        m_pha = 0;
        m_phb = 0;
        for (int i = 0; i < 15; i++) m_hist[i] = '0;
        sb.delete();
    endtask

    // Driver: computes the expected sample pair and pushes it, then strobes.
    task automatic strobe(string tag);
        item_t it;
        logic [31:0] ra, rb, bd;
        @(negedge clk);
        ra = src_ref(a_src, a_dc, m_pha, a_amp);
        rb = src_ref(b_src, b_dc, m_phb, b_amp);
        bd = (b_lag == 0) ? rb : m_hist[b_lag - 1];
        it.a = sum_en ? sat_ref(ra, bd) : ra;
        it.b = bd;
        for (int i = 14; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = rb;
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        m_pha = (m_pha + int'(a_step)) % 3072;
        m_phb = (m_phb + int'(b_step)) % 3072;
        it.l = m_lfsr;
        it.tag = tag;
        sb.push_back(it);
        smp_en = 1'b1;
        @(negedge clk);
        smp_en = 1'b0;
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) took = smp_en & ~rst;

    // Monitor: pops the oldest expected item one cycle after each strobe.
    always @(negedge clk) begin
        if (took && sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            check(e.tag, {a_out, b_out}, {e.a, e.b});
            check({e.tag, " R3 lfsr"}, {48'h0, lfsr_state}, {48'h0, e.l});
            last_a = e.a;
            last_b = e.b;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 reset outputs", {a_out, b_out}, 64'h0);
        check("R1 reset lfsr", {48'h0, lfsr_state}, {48'h0, 16'h0001});

        // R5 constants, R2 hold between strobes
        a_src = 2'd0; a_dc = 32'h1234_5678;
        b_src = 2'd0; b_dc = 32'hEDCB_A987;
        repeat (3) strobe("R5 dc");
        repeat (4) @(negedge clk);
        check("R2 hold", {a_out, b_out, 16'h0}, {last_a, last_b, 16'h0});
        check("R2 lfsr hold", {48'h0, lfsr_state}, {48'h0, m_lfsr});

        // R3 R4 shared pseudo-random
        a_src = 2'd1; b_src = 2'd1;
        repeat (40) strobe("R4 prbs both");

        // R5 code 3, R10 channel independence
        a_src = 2'd3; b_src = 2'd1;
        repeat (3) strobe("R5 R10 mute A prbs B");

        // R6 R7 sine in all quadrants, wrap, wide product
        a_src = 2'd2; a_step = 11'd64;   a_amp = 16'd1;
        b_src = 2'd2; b_step = 11'd1535; b_amp = 16'hFFFF;
        repeat (100) strobe("R6 R7 sine");
        a_step = 11'd7; a_amp = 16'd300;
        b_src = 2'd0; b_dc = 32'h0F0F_0F0F;
        repeat (50) strobe("R6 R10 sine A dc B");

        // R8 lag on a changing stream
        b_src = 2'd1; b_lag = 4'd5;
        repeat (20) strobe("R8 lag5");
        b_lag = 4'd15;
        repeat (20) strobe("R8 lag15");

        // R8 zero fill after reset
        do_reset();
        b_src = 2'd0; b_dc = 32'd5; b_lag = 4'd3;
        repeat (6) strobe("R8 zero fill");

        // R9 saturated sum
        b_lag = 4'd0; sum_en = 1'b1;
        a_src = 2'd0; a_dc = 32'h7FFF_FFF0; b_dc = 32'h0000_0100;
        strobe("R9 sat high");
        a_dc = 32'h8000_0010; b_dc = 32'hFFFF_FF00;
        strobe("R9 sat low");
        a_dc = 32'd100; b_dc = -32'sd30;
        strobe("R9 mid");
        a_src = 2'd2; a_step = 11'd100; a_amp = 16'd1000; b_src = 2'd1; b_lag = 4'd2;
        repeat (20) strobe("R9 sine plus prbs");
        sum_en = 1'b0;

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule